// File: doc/BRIEF.md
# Load/Store Multicycle Processor Core

This core runs a program made of only two kinds of 32-bit instructions: one that copies a word from data memory into a register, and one that copies a register into data memory. It is meant to shuttle grayscale pixel words between a wide register file and a small local RAM. Each instruction is executed over several clock cycles by a sequence controller. A copy into a register takes four cycles and a copy into memory takes three.

Every instruction names three things. The first is a base register, taken from a 5-bit field. The second is a target register, taken from an 8-bit field. The third is a signed 16-bit offset. The memory address is the base register's value plus the sign-extended offset, formed by an adder that does nothing else. Instruction memory and data memory are internal arrays. Each has a write port, so that an environment can preload it while the core is held in reset. Debug outputs show the program counter, the controller state, the effective address, and any register-file write in progress.

Top module: `lsproc_core`

## Requirements
- R1: Synchronous reset sets the PC to 0 and the state to FETCH (code 0), and clears all 256 registers to zero. After reset, the core starts fetching at address 0.
- R2: Instruction bit 31 selects the operation: 1 is a load, 0 is a store. Bits [30:26] give the base register, bits [23:16] give the target register, and bits [15:0] give the offset. The word 0x80010041 is a load into register 1 with base register 0 and offset 0x41.
- R3: In FETCH, the word at instruction-memory index PC[..:2] is captured and the PC advances by 4. The PC therefore equals 4×n when the n-th instruction (counting from 0) is fetched.
- R4: A load passes through the states FETCH(0), DECODE(1), READ(2) and WRITEBACK(3), then returns to FETCH.
- R5: A store passes through the states FETCH(0), DECODE(1) and WRITE(4), then returns to FETCH.
- R6: The effective address is the base value plus the sign-extended offset, modulo 2^32. It is shown on `dbg_addr` during READ and WRITE. Negative offsets and a result of 0xFFFFFFFF must be handled correctly.
- R7: A load writes the addressed memory word into the target register. `dbg_rf_we` is high only in WRITEBACK, and during that cycle `dbg_rf_idx` and `dbg_rf_data` show the target index and the value being written.
- R8: A store writes the target register's value into data memory at the effective address. A later load from that address returns the stored value. A store never raises `dbg_rf_we`.
- R9: Data memory is word-indexed by the low log2(DMEM_DEPTH) bits of the effective address. Addresses beyond the depth wrap around.
- R10: Instruction bits [25:24] are ignored.
- R11: Target registers above 31 can be written by a load and used as the source of a store. Base registers are limited to 0..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction memory preload strobe |
| imem_waddr | input | $clog2(IMEM_DEPTH) | Instruction memory preload word index |
| imem_wdata | input | 32 | Instruction memory preload word |
| dmem_we | input | 1 | Data memory preload strobe |
| dmem_waddr | input | $clog2(DMEM_DEPTH) | Data memory preload word index |
| dmem_wdata | input | 32 | Data memory preload word |
| dbg_pc | output | 32 | Program counter |
| dbg_state | output | 3 | Controller state code |
| dbg_addr | output | 32 | Effective address of the current instruction |
| dbg_rf_we | output | 1 | Register-file write in progress |
| dbg_rf_idx | output | 8 | Index of register being written |
| dbg_rf_data | output | 32 | Value being written |

## Verification
The bench builds the core with IMEM_DEPTH = 32 and DMEM_DEPTH = 64. With this small data depth, the wrap-around of R9 can be reached by ordinary offsets such as 0x41 and 0x7FFF, and by the all-ones address. A 14-instruction program mixes loads and stores. It covers negative offsets, a target register index of 200, and instructions with bits [25:24] set. It also includes a store followed by a load from the same address, and a load that overwrites its own base register. Afterwards, a reset is applied in the middle of an instruction and a new program is loaded. That program stores a register that held a value before the reset, which shows that the register file was cleared.

// File: rtl/lsproc_core.sv
module lsproc_core #(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          imem_we,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_waddr,
  input  logic [31:0]                   imem_wdata,
  input  logic                          dmem_we,
  input  logic [$clog2(DMEM_DEPTH)-1:0] dmem_waddr,
  input  logic [31:0]                   dmem_wdata,
  output logic [31:0]                   dbg_pc,
  output logic [2:0]                    dbg_state,
  output logic [31:0]                   dbg_addr,
  output logic                          dbg_rf_we,
  output logic [7:0]                    dbg_rf_idx,
  output logic [31:0]                   dbg_rf_data
);
  localparam int IA_W  = $clog2(IMEM_DEPTH);
  localparam int DA_W  = $clog2(DMEM_DEPTH);
  localparam int NREGS = 256;

  localparam logic [2:0] S_FETCH = 3'd0;
  localparam logic [2:0] S_DEC   = 3'd1;
  localparam logic [2:0] S_READ  = 3'd2;
  localparam logic [2:0] S_WB    = 3'd3;
  localparam logic [2:0] S_WRITE = 3'd4;

  logic [31:0] imem [IMEM_DEPTH];
  logic [31:0] dmem [DMEM_DEPTH];
  logic [31:0] rf   [NREGS];

  logic [31:0] pc, base_q, src_q, mdr;
  logic [29:0] ir;
  logic [2:0]  state;

  wire         is_load = ir[29];
  wire [4:0]   rs      = ir[28:24];
  wire [7:0]   rt      = ir[23:16];
  wire [31:0]  ea      = base_q + {{16{ir[15]}}, ir[15:0]};
  wire [DA_W-1:0] dslot = ea[DA_W-1:0];
  wire [IA_W-1:0] islot = pc[IA_W+1:2];

  always_ff @(posedge clk)
    if (imem_we) imem[imem_waddr] <= imem_wdata;

  always_ff @(posedge clk) begin
    if (dmem_we) dmem[dmem_waddr] <= dmem_wdata;
    if (!rst && state == S_WRITE) dmem[dslot] <= src_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (state == S_WB) begin
      rf[rt] <= mdr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      state  <= S_FETCH;
      ir     <= '0;
      base_q <= '0;
      src_q  <= '0;
      mdr    <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= {imem[islot][31:26], imem[islot][23:0]};
          pc    <= pc + 32'd4;
          state <= S_DEC;
        end
        S_DEC: begin
          base_q <= rf[{3'b000, rs}];
          src_q  <= rf[rt];
          state  <= is_load ? S_READ : S_WRITE;
        end
        S_READ: begin
          mdr   <= dmem[dslot];
          state <= S_WB;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  assign dbg_pc      = pc;
  assign dbg_state   = state;
  assign dbg_addr    = ea;
  assign dbg_rf_we   = (state == S_WB);
  assign dbg_rf_idx  = rt;
  assign dbg_rf_data = mdr;
endmodule

// File: rtl/lsproc_core_chk.sv
module lsproc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [2:0]  state,
  input logic [29:0] ir,
  input logic        rf_we
);
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (pc == 32'd0 && state == 3'd0));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    state == 3'd0 |=> pc == $past(pc) + 32'd4);

  assert_decode_R2: assert property (@(posedge clk) disable iff (rst)
    state == 3'd1 |=> state == ($past(ir[29]) ? 3'd2 : 3'd4));

  assert_read_next_R4: assert property (@(posedge clk) disable iff (rst)
    state == 3'd2 |=> state == 3'd3);

  assert_wb_next_R4: assert property (@(posedge clk) disable iff (rst)
    state == 3'd3 |=> state == 3'd0);

  assert_write_next_R5: assert property (@(posedge clk) disable iff (rst)
    state == 3'd4 |=> state == 3'd0);

  assert_rf_we_single_R7: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> (!rf_we && state == 3'd0));

  assert_state_legal_R4: assert property (@(posedge clk) disable iff (rst)
    state <= 3'd4);
endmodule

bind lsproc_core lsproc_core_chk chk (
  .clk(clk), .rst(rst), .pc(pc), .state(state), .ir(ir), .rf_we(dbg_rf_we)
);

// File: tb/lsproc_core_test.sv
`timescale 1ns/1ps
module lsproc_core_test;
  localparam int ID = 32;
  localparam int DD = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imem_we = 1'b0, dmem_we = 1'b0;
  logic [$clog2(ID)-1:0] imem_waddr = '0;
  logic [$clog2(DD)-1:0] dmem_waddr = '0;
  logic [31:0] imem_wdata = '0, dmem_wdata = '0;
  logic [31:0] dbg_pc, dbg_addr, dbg_rf_data;
  logic [2:0]  dbg_state;
  logic        dbg_rf_we;
  logic [7:0]  dbg_rf_idx;

  always #2.5 clk = ~clk;

  lsproc_core #(.IMEM_DEPTH(ID), .DMEM_DEPTH(DD)) uut (
    .clk(clk), .rst(rst),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
    .dbg_pc(dbg_pc), .dbg_state(dbg_state), .dbg_addr(dbg_addr),
    .dbg_rf_we(dbg_rf_we), .dbg_rf_idx(dbg_rf_idx), .dbg_rf_data(dbg_rf_data)
  );

  // {instruction, expected effective address, expected loaded value}
  localparam int NV = 14;
  localparam logic [95:0] VEC [NV] = '{
    {32'h80010041, 32'h00000041, 32'h10000001},  // R2 example, R9 wrap 0x41 -> 1
    {32'h80020005, 32'h00000005, 32'h10000005},
    {32'h8003000A, 32'h0000000A, 32'h00000014},  // r3 = 20
    {32'h0C02FFFD, 32'h00000011, 32'h00000000},  // R6 store r2 -> [r3-3]
    {32'h8C04FFFD, 32'h00000011, 32'h10000005},  // R8 read back
    {32'h83C80002, 32'h00000002, 32'h10000002},  // R10 bits 25:24 set, R11 rt=200
    {32'h00C80028, 32'h00000028, 32'h00000000},  // R11 store r200
    {32'h80050028, 32'h00000028, 32'h10000002},
    {32'h0C017FFF, 32'h00008013, 32'h00000000},  // R9 wrap to slot 19
    {32'h80060013, 32'h00000013, 32'h10000001},
    {32'h8007FFFF, 32'hFFFFFFFF, 32'h1000003F},  // R6 all-ones address -> slot 63
    {32'h8C030001, 32'h00000015, 32'h10000015},  // overwrite own base
    {32'h00000005, 32'h00000005, 32'h00000000},  // store r0
    {32'h80080005, 32'h00000005, 32'h00000000}
  };

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_i(input int a, input logic [31:0] d);
    @(negedge clk); imem_we = 1'b1; imem_waddr = a[$clog2(ID)-1:0]; imem_wdata = d;
    @(negedge clk); imem_we = 1'b0;
  endtask

  task automatic wr_d(input int a, input logic [31:0] d);
    @(negedge clk); dmem_we = 1'b1; dmem_waddr = a[$clog2(DD)-1:0]; dmem_wdata = d;
    @(negedge clk); dmem_we = 1'b0;
  endtask

  // Walk one instruction; at entry we are at a negedge with the core in FETCH.
  task automatic run_instr(input int n, input logic [31:0] ins, input logic [31:0] eaddr,
                           input logic [31:0] data);
    chk("R3 pc at fetch", dbg_pc, 32'(n * 4));
    chk("R4/R5 fetch state", {29'd0, dbg_state}, 32'd0);
    @(negedge clk);
    chk("R4/R5 decode state", {29'd0, dbg_state}, 32'd1);
    chk("R7 no write in decode", {31'd0, dbg_rf_we}, 32'd0);
    @(negedge clk);
    if (ins[31]) begin
      chk("R2/R4 read state", {29'd0, dbg_state}, 32'd2);
      chk("R6 load address", dbg_addr, eaddr);
      @(negedge clk);
      chk("R4 writeback state", {29'd0, dbg_state}, 32'd3);
      chk("R7 write strobe", {31'd0, dbg_rf_we}, 32'd1);
      chk("R7/R11 target index", {24'd0, dbg_rf_idx}, {24'd0, ins[23:16]});
      chk("R7/R8/R9 loaded value", dbg_rf_data, data);
    end else begin
      chk("R2/R5 write state", {29'd0, dbg_state}, 32'd4);
      chk("R6 store address", dbg_addr, eaddr);
      chk("R8 store makes no reg write", {31'd0, dbg_rf_we}, 32'd0);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < NV; k++) wr_i(k, VEC[k][95:64]);
    for (int k = 0; k < DD; k++) wr_d(k, (k == 10) ? 32'd20 : (32'h10000000 | 32'(k)));
    @(negedge clk);
    chk("R1 reset pc", dbg_pc, 32'd0);
    chk("R1 reset state", {29'd0, dbg_state}, 32'd0);
    rst = 1'b0;
    chk("R1 no write after reset", {31'd0, dbg_rf_we}, 32'd0);
    for (int v = 0; v < NV; v++) run_instr(v, VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);

    // Reset mid-instruction, then show register file was cleared (r2 held 0x10000005).
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset pc", dbg_pc, 32'd0);
    chk("R1 mid-run reset state", {29'd0, dbg_state}, 32'd0);
    wr_i(0, 32'h00020032);   // store r2 -> [50]
    wr_i(1, 32'h80090032);   // load r9 <- [50]
    wr_d(50, 32'hDEADBEEF);
    @(negedge clk);
    rst = 1'b0;
    run_instr(0, 32'h00020032, 32'h00000032, 32'h0);
    run_instr(1, 32'h80090032, 32'h00000032, 32'h0);   // R1 registers cleared
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule